// File: doc/BRIEF.md
# Dual Timebase Prescaler Generator

This block supplies two free-running timebase counters for a bank of timer channels. The first timebase advances from a two-stage prescaler fed by the system clock. The first stage divides by 4 or by 32. The second stage divides that result by 1, 2, 4 or 8. The second timebase follows an external pin in one of two ways. The pin can serve directly as its clock. It can also serve as a gate that lets an internal divide-by-8 clock through only while the pin is high.

The pin is asynchronous, so the block synchronizes it and detects its edges internally. The configuration fields arrive as static inputs from a host register. The outputs are the two counter values and a one-cycle tick enable for each counter. A counter increments on the clock edge that closes the cycle in which its tick is high. Changes to a prescaler divisor never produce a shortened period: each stage picks up a new divisor only at its own terminal count.

Top module: `dual_timebase_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, both counters clear to zero and both ticks are low after that edge.
- R2: The first prescaler stage divides the system clock by 4 when `cfg_pre_slow` is 0 and by 32 when it is 1.
- R3: The second prescaler stage divides the first stage's output by 1, 2, 4 or 8 for `cfg_pre_sel` values 00, 01, 10 and 11. `tb1_tick` therefore recurs every (first divisor × second divisor) cycles.
- R4: `tb1_count` increments by one on each clock edge that ends a cycle with `tb1_tick` high, holds otherwise, and wraps from all ones to zero.
- R5: When `cfg_tb2_gated` is 0 (external clock mode), `tb2_tick` is high for exactly one cycle per rising edge of `tb2_pin`. That cycle begins at the second clock edge after the pin rises. A pin held at a steady level produces no tick.
- R6: When `cfg_tb2_gated` is 1 (gated mode), `tb2_tick` is high on every eighth system clock cycle while the synchronized pin is high, and never while it is low.
- R7: A change to `cfg_pre_slow` or `cfg_pre_sel` takes effect only at the next terminal count of the stage it controls. The period that is already running completes at its old length.
- R8: `tb2_count` increments by one per `tb2_tick`, holds otherwise, and wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_pre_slow | input | 1 | First stage divisor: 0 selects 4, 1 selects 32 |
| cfg_pre_sel | input | 2 | Second stage divisor: 1, 2, 4 or 8 |
| cfg_tb2_gated | input | 1 | 0 = pin is the clock of timebase 2, 1 = pin gates the divide-by-8 clock |
| tb2_pin | input | 1 | Asynchronous external timebase pin |
| tb1_tick | output | 1 | Advance enable for timebase 1 |
| tb1_count | output | CNT_W | Timebase 1 counter value |
| tb2_tick | output | 1 | Advance enable for timebase 2 |
| tb2_count | output | CNT_W | Timebase 2 counter value |

## Verification
On every cycle, the assertions confirm four things. Each prescaler count stays within its limit. A stage's limit changes only at its terminal count. Each counter steps by exactly one per tick and holds otherwise. A gated-mode tick never occurs while the synchronized pin is low, and an external-clock tick never lasts two cycles. Some behaviours only the bench scenarios can show: the actual division ratio for each configuration, that a divisor change leaves the running period at full length, the two-edge latency from the pin to its tick, and the wrap of each counter. The bench shows these by measuring tick intervals and counter values against a cycle-by-cycle reference model.

// File: rtl/dtb_pkg.sv
// Shared types and divisor decoding for the dual timebase generator.
// Assumes divisor limits are expressed as terminal count (divisor - 1).
package dtb_pkg;

    localparam int PRE1_W = 5;   // holds limit 31
    localparam int PRE2_W = 3;   // holds limit 7
    localparam int DIV8_W = 3;

    typedef enum logic {
        TB2_EXT_CLOCK = 1'b0,
        TB2_GATED     = 1'b1
    } tb2_mode_e;

    // First stage terminal count: divide by 4 or 32.
    function automatic logic [PRE1_W-1:0] pre1_limit(input logic slow);
        return slow ? PRE1_W'(31) : PRE1_W'(3);
    endfunction

    // Second stage terminal count: divide by 1, 2, 4 or 8.
    function automatic logic [PRE2_W-1:0] pre2_limit(input logic [1:0] sel);
        logic [PRE2_W-1:0] lim;
        case (sel)
            2'b00:   lim = PRE2_W'(0);
            2'b01:   lim = PRE2_W'(1);
            2'b10:   lim = PRE2_W'(3);
            default: lim = PRE2_W'(7);
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/dtb_divider.sv
// Enabled modulo counter used as one prescaler stage.
// Counts step_in pulses from 0 up to a latched limit and raises tick_out
// combinationally on the step that reaches the limit. The limit is reloaded
// from limit_next only at that terminal count (and during reset), so a
// configuration change never shortens a running period.
module dtb_divider #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_in,
    input  logic [W-1:0] limit_next,
    output logic         tick_out
);

    logic [W-1:0] cnt;
    logic [W-1:0] lim;

    // Terminal count of this stage.
    assign tick_out = step_in && (cnt == lim);

    // Advance the phase count and reload the limit at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            lim <= limit_next;
        end else if (step_in) begin
            if (cnt == lim) begin
                cnt <= '0;
                lim <= limit_next;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lim);

    assert_lim_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tick_out)) |-> (lim == $past(lim)));

endmodule

// File: rtl/dtb_pin_sync.sv
// Synchronizer and rising-edge detector for the asynchronous timebase pin.
// Assumes SYNC_STAGES >= 2; level is the last synchronizer stage, and rise
// pulses for one cycle when that level goes from low to high.
module dtb_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise
);

    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;

    // First synchronizer flop samples the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= din;
    end

    // Remaining synchronizer flops.
    for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
        end
    end

    // Previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[SYNC_STAGES-1];
    end

    assign level = chain[SYNC_STAGES-1];
    assign rise  = level && !prev;

endmodule

// File: rtl/dtb_counter.sv
// Free-running timebase counter: increments on each enable, wraps naturally.
module dtb_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    output logic [W-1:0] count
);

    // Advance the timebase on each enable.
    always_ff @(posedge clk) begin
        if (!rst_n)  count <= '0;
        else if (en) count <= count + 1'b1;
    end

    assert_rst_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (count == '0));

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (count == $past(count) + 1'b1));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(count));

endmodule

// File: rtl/dual_timebase_gen.sv
// Dual timebase generator top.
// Timebase 1: system clock -> /4 or /32 stage -> /1,/2,/4,/8 stage -> counter.
// Timebase 2: either synchronized rising edges of tb2_pin, or a free /8 tick
// gated by the synchronized pin level. Configuration inputs are assumed
// quasi-static (host register fields) and are sampled by the stages at their
// terminal counts.
module dual_timebase_gen
    import dtb_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_pre_slow,
    input  logic [1:0]       cfg_pre_sel,
    input  logic             cfg_tb2_gated,
    input  logic             tb2_pin,
    output logic             tb1_tick,
    output logic [CNT_W-1:0] tb1_count,
    output logic             tb2_tick,
    output logic [CNT_W-1:0] tb2_count
);

    localparam logic [DIV8_W-1:0] DIV8_LIMIT = DIV8_W'(7);

    logic              stage1_tick;
    logic              div8_tick;
    logic              pin_level;
    logic              pin_rise;
    logic [PRE1_W-1:0] stage1_lim;
    logic [PRE2_W-1:0] stage2_lim;
    tb2_mode_e         mode;

    // Decode configuration fields into stage limits and mode.
    always_comb begin
        stage1_lim = pre1_limit(cfg_pre_slow);
        stage2_lim = pre2_limit(cfg_pre_sel);
        mode       = tb2_mode_e'(cfg_tb2_gated);
    end

    dtb_divider #(.W(PRE1_W)) u_stage1 (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_in    (1'b1),
        .limit_next (stage1_lim),
        .tick_out   (stage1_tick)
    );

    dtb_divider #(.W(PRE2_W)) u_stage2 (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_in    (stage1_tick),
        .limit_next (stage2_lim),
        .tick_out   (tb1_tick)
    );

    dtb_divider #(.W(DIV8_W)) u_div8 (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_in    (1'b1),
        .limit_next (DIV8_LIMIT),
        .tick_out   (div8_tick)
    );

    dtb_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (tb2_pin),
        .level (pin_level),
        .rise  (pin_rise)
    );

    // Select the timebase 2 enable source.
    always_comb begin
        if (mode == TB2_GATED) tb2_tick = div8_tick && pin_level;
        else                   tb2_tick = pin_rise;
    end

    dtb_counter #(.W(CNT_W)) u_tb1 (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tb1_tick),
        .count (tb1_count)
    );

    dtb_counter #(.W(CNT_W)) u_tb2 (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tb2_tick),
        .count (tb2_count)
    );

    assert_gate_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TB2_GATED && tb2_tick) |-> pin_level);

    assert_edge_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TB2_EXT_CLOCK && tb2_tick) |=> (!tb2_tick || mode == TB2_GATED));

endmodule

// File: tb/dual_timebase_gen_tb.sv
module dual_timebase_gen_tb;

    localparam int CW   = 10;
    localparam int CMAX = 1 << CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_pre_slow = 1'b0;
    logic [1:0]    cfg_pre_sel = 2'b00;
    logic          cfg_tb2_gated = 1'b0;
    logic          tb2_pin = 1'b0;
    logic          tb1_tick, tb2_tick;
    logic [CW-1:0] tb1_count, tb2_count;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;  // 125 MHz

    dual_timebase_gen #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_pre_slow(cfg_pre_slow),
        .cfg_pre_sel(cfg_pre_sel), .cfg_tb2_gated(cfg_tb2_gated),
        .tb2_pin(tb2_pin), .tb1_tick(tb1_tick), .tb1_count(tb1_count),
        .tb2_tick(tb2_tick), .tb2_count(tb2_count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_ph1, m_div1, m_ph2, m_div2, m_ph8, m_n1, m_n2;
    bit p1, p2, p3, mvalid = 0;

    function automatic bit exp_t1();
        return (m_ph1 == m_div1 - 1) && (m_ph2 == m_div2 - 1);
    endfunction

    function automatic bit exp_t2();
        if (cfg_tb2_gated) return (m_ph8 == 7) && p2;
        return p2 && !p3;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_ph1 = 0; m_div1 = cfg_pre_slow ? 32 : 4;
            m_ph2 = 0; m_div2 = 1 << cfg_pre_sel;
            m_ph8 = 0; m_n1 = 0; m_n2 = 0;
            p1 = 0; p2 = 0; p3 = 0; mvalid = 1;
        end else begin
            bit e1, e2, first_done;
            e1 = exp_t1();
            e2 = exp_t2();
            first_done = (m_ph1 == m_div1 - 1);
            if (first_done) begin
                m_ph1 = 0; m_div1 = cfg_pre_slow ? 32 : 4;
                if (m_ph2 == m_div2 - 1) begin
                    m_ph2 = 0; m_div2 = 1 << cfg_pre_sel;
                end else m_ph2++;
            end else m_ph1++;
            m_ph8 = (m_ph8 + 1) % 8;
            if (e1) m_n1 = (m_n1 + 1) % CMAX;
            if (e2) m_n2 = (m_n2 + 1) % CMAX;
            p3 = p2; p2 = p1; p1 = tb2_pin;
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (mvalid) begin
            check(tb1_tick == exp_t1(), cur_req, "tb1_tick", tb1_tick, exp_t1());
            check(tb1_count == CW'(m_n1), cur_req, "tb1_count", tb1_count, m_n1);
            check(tb2_tick == exp_t2(), cur_req, "tb2_tick", tb2_tick, exp_t2());
            check(tb2_count == CW'(m_n2), cur_req, "tb2_count", tb2_count, m_n2);
        end
    end

    // Cycles between two successive tb1 ticks (called at a negedge).
    task automatic tick1_interval(output int n);
        int t0;
        do @(negedge clk); while (!tb1_tick);
        t0 = cyc;
        do @(negedge clk); while (!tb1_tick);
        n = cyc - t0;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n, c0, seen;
        // R1 reset state
        cur_req = "R1";
        repeat (4) @(negedge clk);
        check(tb1_count == 0 && tb2_count == 0, "R1", "counts in reset",
              tb1_count + tb2_count, 0);
        check(!tb1_tick && !tb2_tick, "R1", "ticks in reset", tb1_tick + tb2_tick, 0);
        rst_n = 1'b1;

        // R2 divide by 4, then by 32
        cur_req = "R2";
        tick1_interval(n);
        check(n == 4, "R2", "period /4 /1", n, 4);
        cfg_pre_slow = 1'b1;
        tick1_interval(n); tick1_interval(n);
        check(n == 32, "R2", "period /32 /1", n, 32);
        cfg_pre_slow = 1'b0;
        tick1_interval(n); tick1_interval(n);

        // R3 second stage ratios
        cur_req = "R3";
        for (int s = 0; s < 4; s++) begin
            cfg_pre_sel = 2'(s);
            tick1_interval(n); tick1_interval(n);
            check(n == (4 << s), "R3", "period /4 second stage", n, 4 << s);
        end
        cfg_pre_slow = 1'b1; cfg_pre_sel = 2'b01;
        tick1_interval(n); tick1_interval(n);
        check(n == 64, "R3", "period /32 /2", n, 64);

        // R7 change right after terminal count keeps the running period
        cur_req = "R7";
        cfg_pre_slow = 1'b0; cfg_pre_sel = 2'b11;
        tick1_interval(n); tick1_interval(n);
        do @(negedge clk); while (!tb1_tick);
        @(negedge clk);
        cfg_pre_sel = 2'b00;
        c0 = cyc;
        do @(negedge clk); while (!tb1_tick);
        check(cyc - c0 == 31, "R7", "old period completes", cyc - c0 + 1, 32);
        tick1_interval(n);
        check(n == 4, "R7", "new period after terminal", n, 4);

        // R4 tb1 wrap
        cur_req = "R4";
        while (!(tb1_tick && tb1_count == CW'(CMAX - 1))) @(negedge clk);
        @(negedge clk);
        check(tb1_count == 0, "R4", "tb1 wrap to zero", tb1_count, 0);

        // R5 external clock mode: pulses of varied widths
        cur_req = "R5";
        cfg_tb2_gated = 1'b0;
        repeat (4) @(negedge clk);
        c0 = tb2_count;
        for (int k = 1; k <= 6; k++) begin
            tb2_pin = 1'b1; repeat (k) @(negedge clk);
            tb2_pin = 1'b0; repeat (k + 1) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check(int'(tb2_count) - c0 == 6, "R5", "one tick per rising edge",
              int'(tb2_count) - c0, 6);
        tb2_pin = 1'b1;
        repeat (4) @(negedge clk);
        c0 = tb2_count;
        repeat (40) @(negedge clk);
        check(int'(tb2_count) == c0, "R5", "steady pin no tick", tb2_count, c0);
        tb2_pin = 1'b0;

        // R8 tb2 wrap via fast pin toggling
        cur_req = "R8";
        repeat (4) @(negedge clk);
        seen = 0;
        for (int k = 0; k < 2 * CMAX + 8; k++) begin
            tb2_pin = ~tb2_pin;
            @(negedge clk);
            if (tb2_tick && tb2_count == CW'(CMAX - 1)) begin
                @(negedge clk);
                tb2_pin = ~tb2_pin;
                seen = 1;
                check(tb2_count == 0, "R8", "tb2 wrap to zero", tb2_count, 0);
                break;
            end
        end
        check(seen == 1, "R8", "tb2 reached all ones", seen, 1);
        tb2_pin = 1'b0;

        // R6 gated mode
        cur_req = "R6";
        repeat (4) @(negedge clk);
        cfg_tb2_gated = 1'b1;
        tb2_pin = 1'b1;
        repeat (3) @(negedge clk);
        c0 = tb2_count;
        repeat (80) @(negedge clk);
        check(int'(tb2_count) - c0 == 10, "R6", "ticks in 80 gated-high cycles",
              int'(tb2_count) - c0, 10);
        tb2_pin = 1'b0;
        repeat (3) @(negedge clk);
        c0 = tb2_count;
        repeat (80) @(negedge clk);
        check(int'(tb2_count) == c0, "R6", "no ticks while gate low", tb2_count, c0);

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule